// File: doc/BRIEF.md
# Integer Micro-op Port Steering with Per-Port Scheduling Queues

This block receives a group of up to six decoded integer micro-ops each cycle and places each one into the scheduling queue of one execution port. There are six ports. Ports 0 to 3 are arithmetic ports and ports 4 and 5 compute addresses. Each port owns a 14-entry queue. The arithmetic ports differ in what they can run. Branches may use only two of them. Signed multiply and CRC each have a single home port. Plain arithmetic may use any of the four. Address micro-ops may use only the two address ports.

Placement follows program order within the group. Each micro-op goes to the least-occupied capable port that still has room. If a valid micro-op cannot be placed, that micro-op and every younger one in the group are refused. The refusal is reported upstream so the group can be presented again.

On the issue side, every queue sends at most one entry per cycle to its port. It picks the oldest entry whose ready bit, supplied from outside, is set. A flush input empties every queue in one cycle.

Top module: `int_port_steer`

## Requirements
- R1: After synchronous reset every `q_count` lane reads 0 and no `iss_valid` bit is set.
- R2: Each of the six queues holds at most 14 entries. A queue with 14 entries receives nothing more.
- R3: Class codes on `grp_cls` are: 0 plain arithmetic, 1 branch, 2 signed multiply, 3 CRC, 4 address. Plain arithmetic may be placed on ports 0, 1, 2 or 3. Codes 5 to 7 are never placed.
- R4: A branch goes only to port 0 or port 1. A multiply goes only to port 2. A CRC goes only to port 3. An address micro-op goes only to port 4 or port 5.
- R5: Among the capable ports with free space, a micro-op goes to the one with the lowest occupancy, and a tie goes to the lowest port index. Occupancy is the count at the start of the cycle plus the entries given to older slots of the same group. Entries issued in the same cycle are not subtracted.
- R6: At most two branch micro-ops are accepted per group. A third valid branch is not accepted.
- R7: Slot 0 is the oldest. The first valid micro-op that cannot be placed is refused, together with every younger slot. Invalid slots are skipped and never block. `grp_stall` is 1 exactly when some valid slot is not accepted.
- R8: Up to six micro-ops are accepted in one cycle, with one `grp_accept` bit per slot. Entries sent to the same queue in one cycle are appended in slot order behind the entries already there.
- R9: Bit k of `slot_rdy[p]` belongs to the k-th oldest entry of queue p (k = 0 is the oldest). Each queue issues its lowest-k valid ready entry on `iss_valid[p]` / `iss_tag[p]`, and that entry leaves the queue at the next clock edge.
- R10: While `flush` is 1, nothing is accepted and nothing is issued. All queues read empty after that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty all queues; block acceptance and issue this cycle |
| grp_valid | input | 6 | Valid bit per group slot (slot 0 oldest) |
| grp_cls | input | 6x3 | Class code per slot |
| grp_tag | input | 6x8 | Payload tag per slot |
| slot_rdy | input | 6x14 | Ready bit per queue entry, indexed by age |
| grp_accept | output | 6 | Slot was placed into a queue this cycle |
| grp_stall | output | 1 | Some valid slot was refused |
| iss_valid | output | 6 | Queue issues an entry this cycle |
| iss_tag | output | 6x8 | Tag of the issued entry per port |
| q_count | output | 6x4 | Occupancy of each queue |

## Verification
A corrupted occupancy counter shows up on `q_count` at the next edge. Within the following group, it also sends micro-ops to the wrong port under the lowest-occupancy rule. A wrongly shifted or wrongly appended queue entry appears as an unexpected `iss_tag` when that entry or an older one is next issued. Depending on the ready pattern, that can take a few cycles. The bench keeps its own arithmetic model of all six queues and compares accept, stall and issue outputs in every cycle, so a deviation is caught in the cycle it first reaches a port.

// File: rtl/steer_pkg.sv
package steer_pkg;

    localparam int NUM_PORTS = 6;
    localparam int NUM_ARITH = 4;
    localparam int PORT_W    = $clog2(NUM_PORTS);
    localparam int CLS_W     = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU    = 3'd0,
        CLS_BRANCH = 3'd1,
        CLS_MUL    = 3'd2,
        CLS_CRC    = 3'd3,
        CLS_ADDR   = 3'd4
    } uop_cls_e;

    typedef logic [NUM_PORTS-1:0] port_mask_t;

    localparam port_mask_t ARITH_MASK  = port_mask_t'((1 << NUM_ARITH) - 1);
    localparam port_mask_t ADDR_MASK   = ~ARITH_MASK;
    localparam port_mask_t BRANCH_MASK = port_mask_t'(6'b000011);
    localparam port_mask_t MUL_MASK    = port_mask_t'(6'b000100);
    localparam port_mask_t CRC_MASK    = port_mask_t'(6'b001000);

    function automatic port_mask_t capable_ports(logic [CLS_W-1:0] cls);
        port_mask_t m;
        case (uop_cls_e'(cls))
            CLS_ALU:    m = ARITH_MASK;
            CLS_BRANCH: m = BRANCH_MASK;
            CLS_MUL:    m = MUL_MASK;
            CLS_CRC:    m = CRC_MASK;
            CLS_ADDR:   m = ADDR_MASK;
            default:    m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/uop_steer.sv
module uop_steer
    import steer_pkg::*;
#(
    parameter int GROUP  = 6,
    parameter int DEPTH  = 14,
    parameter int MAX_BR = 2,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                              flush,
    input  logic [GROUP-1:0]                  valid,
    input  logic [GROUP-1:0][CLS_W-1:0]       cls,
    input  logic [NUM_PORTS-1:0][CNT_W-1:0]   occ,
    output logic [GROUP-1:0]                  accept,
    output logic [GROUP-1:0][PORT_W-1:0]      route
);

    logic [NUM_PORTS-1:0][CNT_W-1:0] run_occ;
    logic                            blocked;
    int                              br_seen;
    port_mask_t                      mask;
    logic                            found;
    logic [PORT_W-1:0]               best;

    // Program-order placement: each slot sees the occupancy left by older slots.
    always_comb begin
        run_occ = occ;
        blocked = 1'b0;
        br_seen = 0;
        accept  = '0;
        route   = '0;
        mask    = '0;
        found   = 1'b0;
        best    = '0;
        for (int i = 0; i < GROUP; i++) begin
            if (valid[i] && !blocked && !flush) begin
                mask = capable_ports(cls[i]);
                if (cls[i] == CLS_BRANCH && br_seen >= MAX_BR)
                    mask = '0;
                found = 1'b0;
                best  = '0;
                for (int p = 0; p < NUM_PORTS; p++) begin
                    if (mask[p] && run_occ[p] < CNT_W'(DEPTH) &&
                        (!found || run_occ[p] < run_occ[best])) begin
                        found = 1'b1;
                        best  = PORT_W'(p);
                    end
                end
                if (found) begin
                    accept[i]     = 1'b1;
                    route[i]      = best;
                    run_occ[best] = run_occ[best] + 1'b1;
                    if (cls[i] == CLS_BRANCH)
                        br_seen = br_seen + 1;
                end else begin
                    blocked = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sched_queue.sv
module sched_queue #(
    parameter int DEPTH = 14,
    parameter int GROUP = 6,
    parameter int TAG_W = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic [GROUP-1:0]             push,
    input  logic [GROUP-1:0][TAG_W-1:0]  push_tag,
    input  logic [DEPTH-1:0]             rdy,
    output logic [CNT_W-1:0]             count,
    output logic                         iss_valid,
    output logic [TAG_W-1:0]             iss_tag
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [DEPTH-1:0][TAG_W-1:0] slots, nxt_slots;
    logic [CNT_W-1:0]            count_q, nxt_count;
    logic                        iss_found;
    logic [IDX_W-1:0]            iss_idx;
    int                          wr;

    // Oldest ready entry among the occupied ones (entries kept in age order).
    always_comb begin
        iss_found = 1'b0;
        iss_idx   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (!iss_found && CNT_W'(k) < count_q && rdy[k]) begin
                iss_found = 1'b1;
                iss_idx   = IDX_W'(k);
            end
        end
    end

    assign iss_valid = iss_found && !flush;
    assign iss_tag   = slots[iss_idx];
    assign count     = count_q;

    // Compact over the issued entry, then append pushes in slot order.
    always_comb begin
        nxt_slots = slots;
        if (iss_valid) begin
            for (int k = 0; k < DEPTH - 1; k++) begin
                if (IDX_W'(k) >= iss_idx)
                    nxt_slots[k] = slots[k+1];
            end
        end
        wr = int'(count_q) - (iss_valid ? 1 : 0);
        for (int i = 0; i < GROUP; i++) begin
            if (push[i]) begin
                if (wr < DEPTH)
                    nxt_slots[IDX_W'(wr)] = push_tag[i];
                wr = wr + 1;
            end
        end
        nxt_count = flush ? '0 : CNT_W'(wr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= nxt_count;
        end
        slots <= nxt_slots;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH)); // R2

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> count_q == '0); // R10

    AST_ISSUE_FROM_OCCUPIED: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> count_q != '0); // R9

    AST_ISSUE_REMOVES: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && push == '0 && !flush) |=> count_q == $past(count_q) - 1'b1); // R9

endmodule

// File: rtl/int_port_steer.sv
module int_port_steer
    import steer_pkg::*;
#(
    parameter int GROUP  = 6,
    parameter int DEPTH  = 14,
    parameter int TAG_W  = 8,
    parameter int MAX_BR = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              flush,
    input  logic [GROUP-1:0]                  grp_valid,
    input  logic [GROUP-1:0][CLS_W-1:0]       grp_cls,
    input  logic [GROUP-1:0][TAG_W-1:0]       grp_tag,
    input  logic [NUM_PORTS-1:0][DEPTH-1:0]   slot_rdy,
    output logic [GROUP-1:0]                  grp_accept,
    output logic                              grp_stall,
    output logic [NUM_PORTS-1:0]              iss_valid,
    output logic [NUM_PORTS-1:0][TAG_W-1:0]   iss_tag,
    output logic [NUM_PORTS-1:0][CNT_W-1:0]   q_count
);

    logic [GROUP-1:0][PORT_W-1:0] route;
    logic [GROUP-1:0]             is_branch;

    uop_steer #(
        .GROUP  (GROUP),
        .DEPTH  (DEPTH),
        .MAX_BR (MAX_BR),
        .CNT_W  (CNT_W)
    ) u_steer (
        .flush  (flush),
        .valid  (grp_valid),
        .cls    (grp_cls),
        .occ    (q_count),
        .accept (grp_accept),
        .route  (route)
    );

    assign grp_stall = |(grp_valid & ~grp_accept);

    always_comb begin
        for (int i = 0; i < GROUP; i++)
            is_branch[i] = (grp_cls[i] == CLS_BRANCH);
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [GROUP-1:0] push;
        always_comb begin
            for (int i = 0; i < GROUP; i++)
                push[i] = grp_accept[i] && (route[i] == PORT_W'(p));
        end

        sched_queue #(
            .DEPTH (DEPTH),
            .GROUP (GROUP),
            .TAG_W (TAG_W),
            .CNT_W (CNT_W)
        ) u_queue (
            .clk       (clk),
            .rst       (rst),
            .flush     (flush),
            .push      (push),
            .push_tag  (grp_tag),
            .rdy       (slot_rdy[p]),
            .count     (q_count[p]),
            .iss_valid (iss_valid[p]),
            .iss_tag   (iss_tag[p])
        );
    end

    AST_BRANCH_CAP: assert property (@(posedge clk) disable iff (rst)
        $countones(grp_accept & is_branch) <= MAX_BR); // R6

    AST_FLUSH_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        flush |-> (grp_accept == '0 && iss_valid == '0)); // R10

    for (genvar i = 0; i < GROUP; i++) begin : g_chk
        AST_CAPABLE_PORT: assert property (@(posedge clk) disable iff (rst)
            grp_accept[i] |-> |((capable_ports(grp_cls[i]) >> route[i]) & port_mask_t'(1))); // R4

        AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (rst)
            grp_accept[i] |-> grp_valid[i]); // R7

        if (i > 0) begin : g_order
            AST_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
                (grp_valid[i] && grp_accept[i]) |-> (!grp_valid[i-1] || grp_accept[i-1])); // R7
        end
    end

endmodule

// File: tb/tb_int_port_steer.sv
module tb_int_port_steer;

    localparam int CLK_PERIOD = 10;
    localparam int G  = 6;
    localparam int NP = 6;
    localparam int D  = 14;

    logic                 clk = 1'b0;
    logic                 rst, flush;
    logic [G-1:0]         grp_valid;
    logic [G-1:0][2:0]    grp_cls;
    logic [G-1:0][7:0]    grp_tag;
    logic [NP-1:0][D-1:0] slot_rdy;
    logic [G-1:0]         grp_accept;
    logic                 grp_stall;
    logic [NP-1:0]        iss_valid;
    logic [NP-1:0][7:0]   iss_tag;
    logic [NP-1:0][3:0]   q_count;

    int nchk = 0, nfail = 0, next_tag = 1;
    int mq[NP][D];
    int mc[NP];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_port_steer dut (
        .clk(clk), .rst(rst), .flush(flush), .grp_valid(grp_valid), .grp_cls(grp_cls),
        .grp_tag(grp_tag), .slot_rdy(slot_rdy), .grp_accept(grp_accept), .grp_stall(grp_stall),
        .iss_valid(iss_valid), .iss_tag(iss_tag), .q_count(q_count)
    );

    task automatic chk(input string lbl, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", lbl, what, act, exp);
        end
    endtask

    function automatic int cap_mask(input int c);
        case (c)
            0: return 6'b001111;   // R3 plain arithmetic
            1: return 6'b000011;   // R4 branch
            2: return 6'b000100;   // R4 multiply
            3: return 6'b001000;   // R4 CRC
            4: return 6'b110000;   // R4 address
            default: return 0;     // R3 undefined codes
        endcase
    endfunction

    task automatic clear_grp();
        grp_valid = '0; grp_cls = '0; grp_tag = '0; flush = 1'b0;
    endtask

    task automatic put(input int i, input int c);
        grp_valid[i] = 1'b1;
        grp_cls[i]   = 3'(c);
        grp_tag[i]   = 8'(next_tag);
        next_tag     = (next_tag + 1) % 256;
    endtask

    // One cycle: inputs already driven after a falling edge.
    task automatic cycle(input string lbl);
        int occ[NP];
        int ea[G];
        int er[G];
        int ei[NP];
        int blocked, nb, stall;
        #1;
        for (int p = 0; p < NP; p++) occ[p] = mc[p];
        blocked = 0; nb = 0; stall = 0;
        for (int i = 0; i < G; i++) begin
            ea[i] = 0; er[i] = 0;
            if (grp_valid[i] && !flush) begin
                if (!blocked) begin
                    int m, best;
                    m = cap_mask(int'(grp_cls[i]));
                    if (grp_cls[i] == 3'd1 && nb >= 2) m = 0;
                    best = -1;
                    for (int p = 0; p < NP; p++)
                        if (m[p] && occ[p] < D && (best < 0 || occ[p] < occ[best])) best = p;
                    if (best >= 0) begin
                        ea[i] = 1; er[i] = best; occ[best]++;
                        if (grp_cls[i] == 3'd1) nb++;
                    end else blocked = 1;
                end
            end
            if (grp_valid[i] && !ea[i]) stall = 1;
            chk(lbl, $sformatf("accept slot %0d", i), int'(grp_accept[i]), ea[i]);
        end
        chk(lbl, "stall (R7)", int'(grp_stall), stall);
        for (int p = 0; p < NP; p++) begin
            ei[p] = -1;
            if (!flush)
                for (int k = 0; k < mc[p]; k++)
                    if (ei[p] < 0 && slot_rdy[p][k]) ei[p] = k;
            chk(lbl, $sformatf("issue valid port %0d (R9)", p), int'(iss_valid[p]), ei[p] >= 0);
            if (ei[p] >= 0 && iss_valid[p])
                chk(lbl, $sformatf("issue tag port %0d (R9)", p), int'(iss_tag[p]), mq[p][ei[p]]);
        end
        if (flush) begin
            for (int p = 0; p < NP; p++) mc[p] = 0;
        end else begin
            for (int p = 0; p < NP; p++)
                if (ei[p] >= 0) begin
                    for (int k = ei[p]; k < D - 1; k++) mq[p][k] = mq[p][k+1];
                    mc[p]--;
                end
            for (int i = 0; i < G; i++)
                if (ea[i]) begin
                    mq[er[i]][mc[er[i]]] = int'(grp_tag[i]);
                    mc[er[i]]++;
                end
        end
        @(negedge clk);
        for (int p = 0; p < NP; p++)
            chk(lbl, $sformatf("q_count port %0d (R2)", p), int'(q_count[p]), mc[p]);
    endtask

    initial begin
        rst = 1'b1; clear_grp(); slot_rdy = '0;
        for (int p = 0; p < NP; p++) mc[p] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        for (int p = 0; p < NP; p++) begin
            chk("R1 reset", "q_count", int'(q_count[p]), 0);
            chk("R1 reset", "iss_valid", int'(iss_valid[p]), 0);
        end

        // R3 R5 R8: six plain ops spread by occupancy, ties to low index
        for (int i = 0; i < G; i++) put(i, 0);
        cycle("R3 R5 R8 spread");
        chk("R5 tie", "port0 count", int'(q_count[0]), 2);
        chk("R5 tie", "port3 count", int'(q_count[3]), 1);

        // R10: flush with a pending group and ready entries
        clear_grp(); slot_rdy = '1;
        for (int i = 0; i < G; i++) put(i, 0);
        flush = 1'b1;
        cycle("R10 flush");
        slot_rdy = '0;

        // R4: multiply, CRC and address ops on their ports
        clear_grp();
        put(0, 2); put(1, 2); put(2, 3); put(3, 4); put(4, 4); put(5, 4);
        cycle("R4 restricted");
        chk("R4 restricted", "port2 count", int'(q_count[2]), 2);
        chk("R4 restricted", "port5 count", int'(q_count[5]), 1);

        // R6 R7: third branch refused and younger ALU op held back
        clear_grp();
        put(0, 1); put(1, 1); put(2, 1); put(3, 0);
        cycle("R6 R7 branch cap");
        chk("R6 branch cap", "third branch accept", int'(grp_accept[2]), 0);

        // R9: issue oldest ready entry by age index
        clear_grp();
        slot_rdy[2] = 14'b10;      // second oldest of port 2
        slot_rdy[4] = 14'b11;      // oldest of port 4
        slot_rdy[0] = 14'b100000;  // beyond occupancy: ignored
        cycle("R9 oldest ready");
        slot_rdy = '1;
        repeat (3) cycle("R9 drain");
        slot_rdy = '0;

        // R2 R7: fill the multiply port and observe stall at 14
        clear_grp(); flush = 1'b1; cycle("R10 clear");
        for (int n = 0; n < 3; n++) begin
            clear_grp();
            for (int i = 0; i < G; i++) put(i, 2);
            cycle("R2 R7 full queue");
        end
        chk("R2 full", "port2 count", int'(q_count[2]), 14);
        clear_grp(); put(0, 0); put(2, 2); put(3, 0);   // slot 1 invalid gap
        cycle("R7 gap and full");
        clear_grp(); put(0, 6); put(1, 0);              // undefined class blocks
        cycle("R3 undefined class");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            clear_grp();
            for (int i = 0; i < G; i++) begin
                if ($urandom_range(0, 3) != 0) begin
                    int r;
                    r = $urandom_range(0, 39);
                    if (r < 16) put(i, 0);
                    else if (r < 22) put(i, 1);
                    else if (r < 26) put(i, 2);
                    else if (r < 30) put(i, 3);
                    else if (r < 39) put(i, 4);
                    else put(i, $urandom_range(5, 7));
                end
            end
            for (int p = 0; p < NP; p++)
                for (int k = 0; k < D; k++)
                    slot_rdy[p][k] = ($urandom_range(0, 2) != 0);
            flush = ($urandom_range(0, 59) == 0);
            cycle("random R5 R8 R9");
        end

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule